// File: doc/BRIEF.md
# Triggered Command-Set Sequencer

This block holds a number of command sets. Each set is a small program of up to sixteen command slots, with a control word and a slot-enable mask. Host software fills the slots with a message-ID word, a target address and a data word, sets the bits of the slots to send, then arms the set and fires it by a write to its control word. The engine then walks the enabled slots of the triggered set and presents each one on an outbound valid/ready command channel.

A slot whose message-ID word requests a response holds the engine until a response returns; the response data is stored in the slot. Every slot reports issued and completed flags. When all enabled slots of a set are done, that set's interrupt status bit is raised. The interrupt line is the OR of status bits whose enable bit is set, and status bits are cleared by writing ones.

Register map (byte addresses, 32-bit words, low two address bits zero): global page at 0x000 holds interrupt enable (0x000), interrupt status (0x004, read-only), interrupt clear (0x008, write 1 to clear) and the configuration word (0x00C, read-only). Set s sits at 0x400*(s+1): control at +0x000, slot-enable mask at +0x004, and slot n at +0x100+0x20*n with message ID at +0x00, address at +0x04, data at +0x08, status at +0x0C (read-only) and response data at +0x10 (read-only). Unmapped addresses read zero. Software must not rewrite the slots of a set while that set is being served.

Top module: `cmdset_sequencer`

## Requirements
- R1: After reset, irq and cmdValid are low, and the interrupt enable, interrupt status, every control word, every enable mask and every slot status read as zero.
- R2: The configuration word reads the slot count per set in bits 31:27 and the set count in the 6-bit field at bit 6*DOMAIN; all other bits read zero.
- R3: A set's control word keeps only bit 16 (mode enable) and bit 24 (trigger) and reads back exactly those two written bits; all other bits read zero.
- R4: A set starts only when a write raises its trigger bit from 0 to 1 while its stored mode-enable bit is already 1; a write that sets both bits at once from zero starts nothing.
- R5: Enabled slots are issued in ascending slot order and disabled slots are skipped; each command carries the slot's address and data, cmdWrite equal to message-ID bit 16 and cmdRespReq equal to message-ID bit 8, and holds stable while cmdValid waits for cmdReady.
- R6: Slot status bit 8 is set when the command is accepted and bit 16 when it completes; a slot without the response flag completes on acceptance; starting a set clears the status of all its slots.
- R7: After accepting a command with the response flag, the engine issues nothing more until rspValid is seen; rspData is then stored in that slot's response word.
- R8: When every enabled slot of a triggered set has completed, the set's interrupt status bit is set; writing 1 to that bit of the clear register clears it; irq is high exactly when some status bit with its enable bit set is 1.
- R9: When several sets are waiting to be served, the engine takes the lowest-numbered one first.
- R10: A triggered set with an all-zero enable mask issues no command and still raises its interrupt status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| cmdValid | output | 1 | Command presented |
| cmdReady | input | 1 | Command accepted by downstream |
| cmdAddr | output | 32 | Target address of the command |
| cmdData | output | 32 | Data word of the command |
| cmdWrite | output | 1 | Command is a write |
| cmdRespReq | output | 1 | Command needs a response |
| rspValid | input | 1 | Response for the outstanding command |
| rspData | input | 32 | Response data |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
On every cycle the assertions check that a waiting command stays stable, that nothing is issued after a response-requesting handshake, that a finished set raises its status bit, and that the engine only takes a pending set and never one above a lower pending set. The register semantics, the trigger-only-after-arm rule, the skipping of disabled slots, the stored response data, the interrupt masking and clearing, and the empty-mask case can only be shown by the bench's scenarios, which read the registers back through the normal port.

// File: rtl/cmdset_pkg.sv
package cmdset_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             take;       // start serving set setIdx
    logic             issued;     // slot accepted downstream
    logic             completed;  // slot finished
    logic             setDone;    // set finished, raise interrupt
    logic [IDX_W-1:0] setIdx;
    logic [IDX_W-1:0] slotIdx;
  } ctl_strb_t;
endpackage

// File: rtl/cmdset_datapath.sv
module cmdset_datapath
  import cmdset_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SLOTS    = 4,
  parameter int DOMAIN   = 1,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  ctl_strb_t           strb,
  input  logic [31:0]         rspData,
  output logic [NUM_SETS-1:0] pendVec,
  output logic                selEn,
  output logic [31:0]         selMsgid,
  output logic [31:0]         selAddr,
  output logic [31:0]         selData,
  output logic [NUM_SETS-1:0] irqStat,
  output logic                irq
);
  localparam int PAGE_W = ADDR_W - 10;
  localparam int MODE_BIT = 16;
  localparam int TRIG_BIT = 24;

  logic [NUM_SETS-1:0] ctrlMode, ctrlTrig, irqEn;
  logic [SLOTS-1:0]    enMask   [NUM_SETS];
  logic [31:0]         slotMsg  [NUM_SETS][SLOTS];
  logic [31:0]         slotAddr [NUM_SETS][SLOTS];
  logic [31:0]         slotData [NUM_SETS][SLOTS];
  logic [31:0]         slotResp [NUM_SETS][SLOTS];
  logic                stIssued [NUM_SETS][SLOTS];
  logic                stCompl  [NUM_SETS][SLOTS];

  logic [PAGE_W-1:0] page;
  logic [9:0]        off, slotOff;
  logic [3:0]        slotNum;
  logic [2:0]        word;
  logic              aligned, inSlotArea;
  logic [31:0]       cfgWord;

  assign page       = regAddr[ADDR_W-1:10];
  assign off        = regAddr[9:0];
  assign aligned    = (regAddr[1:0] == 2'b00);
  assign slotOff    = off - 10'h100;
  assign slotNum    = slotOff[8:5];
  assign word       = off[4:2];
  assign inSlotArea = (off[9:8] == 2'b01) || (off[9:8] == 2'b10);

  always_comb begin
    cfgWord = '0;
    cfgWord[31:27] = 5'(SLOTS);
    cfgWord[6*DOMAIN +: 6] = 6'(NUM_SETS);
  end

  // selected slot toward the control and the command port
  always_comb begin
    selEn = 1'b0; selMsgid = '0; selAddr = '0; selData = '0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int n = 0; n < SLOTS; n++)
        if (strb.setIdx == IDX_W'(s) && strb.slotIdx == IDX_W'(n)) begin
          selEn    = enMask[s][n];
          selMsgid = slotMsg[s][n];
          selAddr  = slotAddr[s][n];
          selData  = slotData[s][n];
        end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlMode <= '0; ctrlTrig <= '0; irqEn <= '0; irqStat <= '0; pendVec <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        enMask[s] <= '0;
        for (int n = 0; n < SLOTS; n++) begin
          slotMsg[s][n] <= '0; slotAddr[s][n] <= '0; slotData[s][n] <= '0;
          slotResp[s][n] <= '0; stIssued[s][n] <= 1'b0; stCompl[s][n] <= 1'b0;
        end
      end
    end else begin
      // engine strobes
      for (int s = 0; s < NUM_SETS; s++) begin
        if (strb.setIdx == IDX_W'(s)) begin
          if (strb.take) begin
            pendVec[s] <= 1'b0;
            for (int n = 0; n < SLOTS; n++) begin
              stIssued[s][n] <= 1'b0; stCompl[s][n] <= 1'b0;
            end
          end
          for (int n = 0; n < SLOTS; n++)
            if (strb.slotIdx == IDX_W'(n)) begin
              if (strb.issued) stIssued[s][n] <= 1'b1;
              if (strb.completed) begin
                stCompl[s][n] <= 1'b1;
                if (slotMsg[s][n][8]) slotResp[s][n] <= rspData;
              end
            end
        end
      end
      // host writes
      if (regWe && aligned && page == '0) begin
        if (off == 10'h000) irqEn <= regWdata[NUM_SETS-1:0];
      end
      for (int s = 0; s < NUM_SETS; s++) begin
        if (regWe && aligned && page == PAGE_W'(s + 1)) begin
          if (off == 10'h000) begin
            ctrlMode[s] <= regWdata[MODE_BIT];
            ctrlTrig[s] <= regWdata[TRIG_BIT];
            if (regWdata[TRIG_BIT] && !ctrlTrig[s] && ctrlMode[s]) pendVec[s] <= 1'b1;
          end
          if (off == 10'h004) enMask[s] <= regWdata[SLOTS-1:0];
          for (int n = 0; n < SLOTS; n++)
            if (inSlotArea && slotNum == 4'(n)) begin
              if (word == 3'd0) slotMsg[s][n]  <= regWdata;
              if (word == 3'd1) slotAddr[s][n] <= regWdata;
              if (word == 3'd2) slotData[s][n] <= regWdata;
            end
        end
      end
      // interrupt status: clear first, a same-cycle completion wins
      for (int s = 0; s < NUM_SETS; s++) begin
        if (regWe && aligned && page == '0 && off == 10'h008 && regWdata[s])
          irqStat[s] <= 1'b0;
        if (strb.setDone && strb.setIdx == IDX_W'(s))
          irqStat[s] <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (aligned && page == '0) begin
      case (off)
        10'h000: regRdata = 32'(irqEn);
        10'h004: regRdata = 32'(irqStat);
        10'h00C: regRdata = cfgWord;
        default: regRdata = '0;
      endcase
    end
    for (int s = 0; s < NUM_SETS; s++) begin
      if (aligned && page == PAGE_W'(s + 1)) begin
        if (off == 10'h000)
          regRdata = (32'(ctrlMode[s]) << MODE_BIT) | (32'(ctrlTrig[s]) << TRIG_BIT);
        if (off == 10'h004) regRdata = 32'(enMask[s]);
        for (int n = 0; n < SLOTS; n++)
          if (inSlotArea && slotNum == 4'(n)) begin
            case (word)
              3'd0: regRdata = slotMsg[s][n];
              3'd1: regRdata = slotAddr[s][n];
              3'd2: regRdata = slotData[s][n];
              3'd3: regRdata = (32'(stCompl[s][n]) << 16) | (32'(stIssued[s][n]) << 8);
              3'd4: regRdata = slotResp[s][n];
              default: regRdata = '0;
            endcase
          end
      end
    end
  end

  assign irq = |(irqStat & irqEn);
endmodule

// File: rtl/cmdset_control.sv
module cmdset_control
  import cmdset_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SLOTS    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SETS-1:0] pendVec,
  input  logic                selEn,
  input  logic                selRespReq,
  input  logic                cmdReady,
  input  logic                rspValid,
  output logic                cmdValid,
  output ctl_strb_t           strb
);
  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t           state;
  logic [IDX_W-1:0] curSet, curSlot, pick;
  logic             lastSlot;

  assign lastSlot = (curSlot == IDX_W'(SLOTS - 1));

  always_comb begin
    pick = '0;
    for (int s = NUM_SETS - 1; s >= 0; s--)
      if (pendVec[s]) pick = IDX_W'(s);
  end

  always_comb begin
    strb = '0;
    strb.setIdx  = curSet;
    strb.slotIdx = curSlot;
    cmdValid = 1'b0;
    case (state)
      S_IDLE: if (|pendVec) begin
        strb.take   = 1'b1;
        strb.setIdx = pick;
      end
      S_ISSUE: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          strb.issued    = 1'b1;
          strb.completed = !selRespReq;
        end
      end
      S_WAIT:  strb.completed = rspValid;
      S_DONE:  strb.setDone = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; curSet <= '0; curSlot <= '0;
    end else begin
      case (state)
        S_IDLE: if (|pendVec) begin
          curSet <= pick; curSlot <= '0; state <= S_SCAN;
        end
        S_SCAN: begin
          if (selEn)         state <= S_ISSUE;
          else if (lastSlot) state <= S_DONE;
          else               curSlot <= curSlot + 1'b1;
        end
        S_ISSUE: if (cmdReady) begin
          if (selRespReq)    state <= S_WAIT;
          else if (lastSlot) state <= S_DONE;
          else begin curSlot <= curSlot + 1'b1; state <= S_SCAN; end
        end
        S_WAIT: if (rspValid) begin
          if (lastSlot) state <= S_DONE;
          else begin curSlot <= curSlot + 1'b1; state <= S_SCAN; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdset_sequencer.sv
module cmdset_sequencer
  import cmdset_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SLOTS    = 4,
  parameter int DOMAIN   = 1,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [31:0]       cmdAddr,
  output logic [31:0]       cmdData,
  output logic              cmdWrite,
  output logic              cmdRespReq,
  input  logic              rspValid,
  input  logic [31:0]       rspData,
  output logic              irq
);
  ctl_strb_t           ctlStrb;
  logic [NUM_SETS-1:0] pendVec, irqStat;
  logic                selEn;
  logic [31:0]         selMsgid;

  cmdset_datapath #(.NUM_SETS(NUM_SETS), .SLOTS(SLOTS), .DOMAIN(DOMAIN), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strb(ctlStrb), .rspData(rspData), .pendVec(pendVec),
    .selEn(selEn), .selMsgid(selMsgid), .selAddr(cmdAddr), .selData(cmdData),
    .irqStat(irqStat), .irq(irq)
  );

  cmdset_control #(.NUM_SETS(NUM_SETS), .SLOTS(SLOTS)) u_ctl (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .selEn(selEn),
    .selRespReq(selMsgid[8]), .cmdReady(cmdReady), .rspValid(rspValid),
    .cmdValid(cmdValid), .strb(ctlStrb)
  );

  assign cmdWrite   = selMsgid[16];
  assign cmdRespReq = selMsgid[8];
endmodule

// File: rtl/cmdset_sequencer_chk.sv
module cmdset_sequencer_chk
  import cmdset_pkg::*;
#(
  parameter int NUM_SETS = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic [31:0]         cmdAddr,
  input logic [31:0]         cmdData,
  input logic                cmdRespReq,
  input ctl_strb_t           ctlStrb,
  input logic [NUM_SETS-1:0] pendVec,
  input logic [NUM_SETS-1:0] irqStat
);
  logic selPend, lowerPend, doneBitSet;
  logic [IDX_W-1:0] doneIdxQ;

  always_comb begin
    selPend = 1'b0; lowerPend = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (ctlStrb.setIdx == IDX_W'(s)) selPend = pendVec[s];
      if (IDX_W'(s) < ctlStrb.setIdx && pendVec[s]) lowerPend = 1'b1;
    end
  end

  always_ff @(posedge clk) doneIdxQ <= ctlStrb.setIdx;

  always_comb begin
    doneBitSet = 1'b0;
    for (int s = 0; s < NUM_SETS; s++)
      if (doneIdxQ == IDX_W'(s)) doneBitSet = irqStat[s];
  end

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdData)));

  // R7
  resp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdRespReq) |=> !cmdValid);

  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.setDone |=> doneBitSet);

  // R4
  take_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.take |-> selPend);

  // R9
  take_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.take |-> !lowerPend);
endmodule

bind cmdset_sequencer cmdset_sequencer_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdRespReq(cmdRespReq),
  .ctlStrb(ctlStrb), .pendVec(pendVec), .irqStat(irqStat)
);

// File: tb/cmdset_sequencer_tb.sv
module cmdset_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic cmdValid, cmdReady = 1'b0, cmdWrite, cmdRespReq, irq;
  logic [31:0] cmdAddr, cmdData;
  logic rspValid = 1'b0;
  logic [31:0] rspData = '0;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdset_sequencer #(.NUM_SETS(3), .SLOTS(4), .DOMAIN(1), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdWrite(cmdWrite), .cmdRespReq(cmdRespReq),
    .rspValid(rspValid), .rspData(rspData), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] setA(int s, int o);
    return ADDR_W'(32'h400 * (s + 1) + o);
  endfunction
  function automatic logic [ADDR_W-1:0] slotA(int s, int n, int w);
    return ADDR_W'(32'h400 * (s + 1) + 32'h100 + 32'h20 * n + 4 * w);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic expectCmd(string tag, logic [31:0] a, logic [31:0] d, logic w, logic rr, int hold);
    int waited = 0;
    @(negedge clk);
    while (!cmdValid && waited < 200) begin @(negedge clk); waited++; end
    chk({tag, " valid"}, 32'(cmdValid), 32'd1);
    chk({tag, " addr"}, cmdAddr, a);
    chk({tag, " data"}, cmdData, d);
    chk({tag, " write/resp"}, {30'd0, cmdWrite, cmdRespReq}, {30'd0, w, rr});
    for (int i = 0; i < hold; i++) @(negedge clk);
    cmdReady = 1'b1;
    @(negedge clk); cmdReady = 1'b0;
  endtask

  task automatic sendRsp(logic [31:0] d);
    @(negedge clk); rspValid = 1'b1; rspData = d;
    @(negedge clk); rspValid = 1'b0;
  endtask

  task automatic waitStat(logic [31:0] exp);
    logic [31:0] v = '0;
    for (int i = 0; i < 200 && v != exp; i++) rd(16'h0004, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cmdValid", 32'(cmdValid), 0);
    rd(16'h0000, v); chk("R1 irqEn", v, 0);
    rd(16'h0004, v); chk("R1 irqStat", v, 0);
    rd(setA(1, 0), v); chk("R1 ctrl", v, 0);
    rd(setA(2, 4), v); chk("R1 enable", v, 0);
    rd(slotA(0, 3, 3), v); chk("R1 status", v, 0);
    rd(16'h000C, v); chk("R2 config", v, 32'h2000_00C0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    bit seen = 0;
    wr(setA(0, 0), 32'h0101_0000);
    rd(setA(0, 0), v); chk("R3 readback", v, 32'h0101_0000);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (cmdValid) seen = 1; end
    chk("R4 no start without prior arm", 32'(seen), 0);
    wr(setA(0, 0), 32'h0);
    wr(setA(1, 0), 32'hFFFF_FFFF);
    rd(setA(1, 0), v); chk("R3 other bits zero", v, 32'h0101_0000);
    wr(setA(1, 0), 32'h0);
    rd(16'h0004, v); chk("R4 no completion", v, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    bit seen = 0;
    wr(slotA(0, 0, 0), 32'h0001_0008); wr(slotA(0, 0, 1), 32'h1000); wr(slotA(0, 0, 2), 32'hA0);
    wr(slotA(0, 1, 0), 32'h0001_0008); wr(slotA(0, 1, 1), 32'h1001); wr(slotA(0, 1, 2), 32'hA1);
    wr(slotA(0, 2, 0), 32'h0001_0108); wr(slotA(0, 2, 1), 32'h1002); wr(slotA(0, 2, 2), 32'hA2);
    wr(slotA(0, 3, 0), 32'h0000_0008); wr(slotA(0, 3, 1), 32'h1003); wr(slotA(0, 3, 2), 32'hA3);
    wr(setA(0, 4), 32'hD);
    wr(16'h0000, 32'h1);
    wr(setA(0, 0), 32'h0001_0000);
    wr(setA(0, 0), 32'h0101_0000);
    expectCmd("R5 slot0", 32'h1000, 32'hA0, 1'b1, 1'b0, 2);
    expectCmd("R5 slot2 skips slot1", 32'h1002, 32'hA2, 1'b1, 1'b1, 0);
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (cmdValid) seen = 1; end
    chk("R7 hold while awaiting response", 32'(seen), 0);
    rd(slotA(0, 2, 3), v); chk("R6 issued not complete", v, 32'h0000_0100);
    chk("R8 irq low before done", 32'(irq), 0);
    sendRsp(32'hCAFE);
    expectCmd("R5 slot3 read", 32'h1003, 32'hA3, 1'b0, 1'b0, 0);
    waitStat(32'h1);
    chk("R8 irq raised", 32'(irq), 1);
    rd(slotA(0, 0, 3), v); chk("R6 slot0 done on accept", v, 32'h0001_0100);
    rd(slotA(0, 1, 3), v); chk("R6 disabled slot untouched", v, 0);
    rd(slotA(0, 2, 3), v); chk("R6 slot2 done", v, 32'h0001_0100);
    rd(slotA(0, 2, 4), v); chk("R7 response stored", v, 32'hCAFE);
    wr(16'h0008, 32'h1);
    rd(16'h0004, v); chk("R8 cleared", v, 0);
    chk("R8 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_multi;
    logic [31:0] v;
    wr(16'h0000, 32'h0);
    wr(slotA(2, 0, 0), 32'h0001_0108); wr(slotA(2, 0, 1), 32'h2200); wr(slotA(2, 0, 2), 32'h22);
    wr(slotA(1, 0, 0), 32'h0001_0008); wr(slotA(1, 0, 1), 32'h2100); wr(slotA(1, 0, 2), 32'h21);
    wr(setA(2, 4), 32'h1); wr(setA(1, 4), 32'h1); wr(setA(0, 4), 32'h1);
    wr(setA(0, 0), 32'h0001_0000);
    wr(setA(1, 0), 32'h0001_0000);
    wr(setA(2, 0), 32'h0001_0000);
    wr(setA(2, 0), 32'h0101_0000);
    expectCmd("R7 set2 slot0", 32'h2200, 32'h22, 1'b1, 1'b1, 0);
    wr(setA(1, 0), 32'h0101_0000);
    wr(setA(0, 0), 32'h0101_0000);
    sendRsp(32'h55);
    expectCmd("R9 lowest set first", 32'h1000, 32'hA0, 1'b1, 1'b0, 0);
    expectCmd("R9 then set1", 32'h2100, 32'h21, 1'b1, 1'b0, 0);
    waitStat(32'h7);
    rd(16'h0004, v); chk("R8 all sets done", v, 32'h7);
    chk("R8 masked irq", 32'(irq), 0);
    wr(16'h0000, 32'h4);
    chk("R8 enabled irq", 32'(irq), 1);
    wr(16'h0008, 32'h4);
    chk("R8 irq after clearing enabled bit", 32'(irq), 0);
    wr(16'h0008, 32'h3);
    rd(16'h0004, v); chk("R8 all cleared", v, 0);
  endtask

  task automatic t_empty;
    logic [31:0] v;
    bit seen = 0;
    wr(setA(0, 0), 32'h0001_0000);
    wr(setA(0, 4), 32'h0);
    wr(setA(0, 0), 32'h0101_0000);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (cmdValid) seen = 1; end
    chk("R10 no command", 32'(seen), 0);
    rd(16'h0004, v); chk("R10 status raised", v, 32'h1);
    rd(slotA(0, 0, 3), v); chk("R6 status cleared on start", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_basic();
    t_multi();
    t_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule